// File: doc/BRIEF.md
# Digital Second-Order Sigma-Delta Modulator

This block turns a stream of signed fixed-point samples, one per oversampling clock, into a single-bit pulse-density stream whose running ±1 average follows the input. It sits after the interpolation stage of an oversampled digital-to-analog path. The single bit drives a two-level output stage, and an analog low-pass filter recovers the signal from it. The loop is built from two cascaded delaying accumulators with one-bit feedback. A mode input picks one-loop (first-order) or two-loop (second-order) noise shaping.

Two measures protect against overload. Each accumulator saturates at a magnitude set on an input port instead of wrapping. A run-length guard watches the output, and when the same bit repeats more times than a programmable count it zeroes both accumulators so the loop can start again. A clock enable moves the loop forward one sample at a time.

Top module: `sdm_mod`

## Requirements
- R1: `bit_o` is 1 exactly when the accumulator that feeds the quantizer holds a value greater than or equal to zero. Full scale is FS = 2^15. At each accumulator input the loop subtracts +FS when `bit_o` is 1 and subtracts -FS when `bit_o` is 0.
- R2: The accumulators delay by one sample. On each enabled clock the first one adds the sign-extended `sample_i` minus the feedback, and the second adds the first accumulator's pre-update value minus the feedback.
- R3: When `order_sel` = 0 the quantizer reads the first accumulator and the second is held at zero. With zero input after reset, the output alternates 1,0,1,0,...
- R4: When `order_sel` = 1 the quantizer reads the second accumulator.
- R5: After each update an accumulator lies within ±`clamp_lim`, and a result beyond that range is clipped to the nearest bound instead of wrapping.
- R6: A run is the count of consecutive identical output bits. If the new run length on an enabled clock exceeds a nonzero `run_lim`, both accumulators are set to zero on that clock instead of updating, and the run count starts over. With `run_lim` = 0 the guard never acts.
- R7: Synchronous active-high `rst` clears both accumulators and the run state, which leaves `bit_o` at 1.
- R8: While `ce` is low, the accumulators, the run state and (for a fixed mode) `bit_o` all stay unchanged, whatever `sample_i` does.
- R9: For a constant input with magnitude up to FS/2 in either mode, the ±1 mean over 4096 samples from reset is within 1/256 of `sample_i`/FS.
- R10: In first-order mode with `sample_i` = 6554 (about 0.2 FS), the first ten bits after reset are 1,0,1,0,1,1,0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Advance the loop by one sample |
| order_sel | input | 1 | 0 = first-order loop, 1 = second-order loop |
| sample_i | input | 16 | Signed input sample |
| clamp_lim | input | 19 | Accumulator saturation magnitude |
| run_lim | input | 8 | Longest allowed run of equal bits; 0 disables the guard |
| bit_o | output | 1 | Pulse-density output bit |

## Verification
The bound check on the accumulators compares each update against the limit that was in force on that same edge. It assumes `clamp_lim` changes only while `ce` is low, and the stimulus obeys this by reprogramming limits only between runs and after a reset. The run-count bound and the idle-stage check likewise expect `run_lim` and `order_sel` to stay fixed while samples flow. The driver keeps mode and limits constant within each stimulus burst and toggles `sample_i` only during the idle gaps.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int SDM_IN_W    = 16;
    localparam int SDM_ACC_W   = 20;
    localparam int SDM_RUN_W   = 8;
    localparam int SDM_STAGES  = 2;
    localparam int SDM_LIM_W   = SDM_ACC_W - 1;
    localparam int SDM_WIDE_W  = SDM_ACC_W + 2;
    localparam int SDM_FS      = 2 ** (SDM_IN_W - 1);

    typedef enum logic {
        ORDER_ONE = 1'b0,
        ORDER_TWO = 1'b1
    } order_e;

    typedef logic signed [SDM_ACC_W-1:0]  acc_t;
    typedef logic signed [SDM_WIDE_W-1:0] wide_t;
    typedef logic        [SDM_LIM_W-1:0]  lim_t;

    // saturate a widened sum to +/- lim
    function automatic acc_t clip(input wide_t v, input lim_t lim);
        wide_t hi;
        wide_t lo;
        acc_t  r;
        hi = $signed({3'b000, lim});
        lo = -hi;
        if (v > hi)
            r = hi[SDM_ACC_W-1:0];
        else if (v < lo)
            r = lo[SDM_ACC_W-1:0];
        else
            r = v[SDM_ACC_W-1:0];
        return r;
    endfunction

    function automatic wide_t widen(input acc_t a);
        return {{(SDM_WIDE_W-SDM_ACC_W){a[SDM_ACC_W-1]}}, a};
    endfunction

endpackage

// File: rtl/sdm_integ.sv
module sdm_integ
    import sdm_pkg::*;
#(
    parameter int FS_VAL = SDM_FS
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic clr,
    input  acc_t addend,
    input  logic fb_pos,
    input  lim_t lim,
    output acc_t acc_q
);

    localparam wide_t FS_W = wide_t'(FS_VAL);

    wide_t sum;

    always_comb begin
        sum = widen(acc_q) + widen(addend) + (fb_pos ? -FS_W : FS_W);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (ce)
            acc_q <= clr ? '0 : clip(sum, lim);
    end

    // R5
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ce) |-> (acc_q <= $signed({1'b0, $past(lim)}) &&
                       acc_q >= -$signed({1'b0, $past(lim)})));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(acc_q));

endmodule

// File: rtl/sdm_runguard.sv
module sdm_runguard
    import sdm_pkg::*;
#(
    parameter int RUN_W = SDM_RUN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             bit_i,
    input  logic [RUN_W-1:0] lim,
    output logic             trip
);

    logic             last_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W:0]   len;

    always_comb begin
        if (run_q != '0 && bit_i == last_q)
            len = {1'b0, run_q} + 1'b1;
        else
            len = (RUN_W+1)'(1);
        trip = ce && (lim != '0) && (len > {1'b0, lim});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            run_q  <= '0;
        end else if (ce) begin
            last_q <= bit_i;
            if (trip)
                run_q <= '0;
            else if (len[RUN_W])
                run_q <= '1;
            else
                run_q <= len[RUN_W-1:0];
        end
    end

    // R6
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && $past(lim) != '0) |-> run_q <= $past(lim));

    // R8
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(run_q) && $stable(last_q)));

endmodule

// File: rtl/sdm_mod.sv
module sdm_mod
    import sdm_pkg::*;
#(
    parameter int IN_W   = SDM_IN_W,
    parameter int ACC_W  = SDM_ACC_W,
    parameter int RUN_W  = SDM_RUN_W,
    parameter int STAGES = SDM_STAGES
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic                   order_sel,
    input  logic signed [IN_W-1:0] sample_i,
    input  logic [ACC_W-2:0]       clamp_lim,
    input  logic [RUN_W-1:0]       run_lim,
    output logic                   bit_o
);

    localparam int EXT_W = ACC_W - IN_W;

    acc_t   stage_q [STAGES];
    acc_t   stage_in[STAGES];
    logic   stage_clr[STAGES];
    logic   trip;
    order_e mode;
    acc_t   q_src;

    assign mode = order_e'(order_sel);

    // quantizer: pick the last active accumulator
    always_comb begin
        q_src = (mode == ORDER_TWO) ? stage_q[STAGES-1] : stage_q[0];
        bit_o = ~q_src[ACC_W-1];
    end

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_head
                assign stage_in[k]  = {{EXT_W{sample_i[IN_W-1]}}, sample_i};
                assign stage_clr[k] = trip;
            end else begin : g_tail
                assign stage_in[k]  = stage_q[k-1];
                assign stage_clr[k] = trip | (mode == ORDER_ONE);
            end
            sdm_integ #(.FS_VAL(2 ** (IN_W - 1))) u_integ (
                .clk    (clk),
                .rst    (rst),
                .ce     (ce),
                .clr    (stage_clr[k]),
                .addend (stage_in[k]),
                .fb_pos (bit_o),
                .lim    (clamp_lim),
                .acc_q  (stage_q[k])
            );
        end
    endgenerate

    sdm_runguard #(.RUN_W(RUN_W)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .bit_i (bit_o),
        .lim   (run_lim),
        .trip  (trip)
    );

    // R6
    trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(trip) |-> (stage_q[0] == '0 && stage_q[STAGES-1] == '0));

    // R3
    idle_stage_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ce) && !$past(order_sel)) |-> stage_q[STAGES-1] == '0);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stage_q[0] == '0 && stage_q[STAGES-1] == '0 && bit_o));

endmodule

// File: tb/sim_sdm_mod.sv
`timescale 1ns/1ps
module sim_sdm_mod;

    localparam longint FS = 32768;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ce = 1'b0;
    logic               order_sel = 1'b0;
    logic signed [15:0] sample_i = '0;
    logic [18:0]        clamp_lim = '1;
    logic [7:0]         run_lim = '0;
    logic               bit_o;

    always #2 clk = ~clk;

    sdm_mod u0 (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .order_sel (order_sel),
        .sample_i  (sample_i),
        .clamp_lim (clamp_lim),
        .run_lim   (run_lim),
        .bit_o     (bit_o)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    exp_q[$];
    bit    log_q[$];

    longint m1, m2;
    int     mrun;
    bit     mlast;

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint clipm(input longint v, input longint l);
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    // reference model built from the requirements
    function automatic bit model_step(input longint x, input bit ord);
        bit     y;
        longint fb, n1, n2, lim;
        int     len;
        lim = longint'(clamp_lim);
        y   = ord ? (m2 >= 0) : (m1 >= 0);
        fb  = y ? FS : -FS;
        len = (mrun != 0 && y == mlast) ? mrun + 1 : 1;
        if (run_lim != 0 && len > int'(run_lim)) begin
            m1 = 0; m2 = 0; mrun = 0;
        end else begin
            n1 = clipm(m1 + x - fb, lim);
            n2 = ord ? clipm(m2 + m1 - fb, lim) : 0;
            m1 = n1; m2 = n2;
            mrun = (len > 255) ? 255 : len;
        end
        mlast = y;
        return y;
    endfunction

    // monitor: pop expected bits as the design produces them
    always @(negedge clk) begin
        #1;
        if (ce && !rst) begin
            bit e;
            if (exp_q.size() == 0) begin
                check(1'b0, tag, "unexpected sample", bit_o, 0);
            end else begin
                e = exp_q.pop_front();
                check(bit_o == e, tag, "stream bit", bit_o, e);
                log_q.push_back(bit_o);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ce  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m1 = 0; m2 = 0; mrun = 0; mlast = 1'b0;
        log_q.delete();
        #1;
        check(bit_o == 1'b1, "R7", "bit after reset", bit_o, 1);
    endtask

    // driver: push expected bits, optionally with idle gaps
    task automatic drive(input longint x, input bit ord, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_i  = 16'(x);
            order_sel = ord;
            ce        = 1'b1;
            exp_q.push_back(model_step(x, ord));
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk);
                ce = 1'b0;
                sample_i = ~sample_i;
                @(negedge clk);
            end
        end
        @(negedge clk);
        ce = 1'b0;
    endtask

    function automatic int ones();
        int c = 0;
        foreach (log_q[i]) c += log_q[i];
        return c;
    endfunction

    task automatic mean_chk(input longint x);
        longint n, s, err;
        n   = log_q.size();
        s   = 2 * ones() - n;
        err = s * FS - x * n;
        if (err < 0) err = -err;
        check(err * 256 <= FS * n, "R9", "mean*FS*n", s * FS, x * n);
    endtask

    initial begin
        bit [9:0] pat;
        bit       held;
        longint   dc[4] = '{0, 6554, -16384, 12124};

        do_reset();

        // R3 zero input, first-order: alternating
        tag = "R3";
        drive(0, 1'b0, 40, 0);
        for (int i = 0; i < 8; i++)
            check(log_q[i] == ((i % 2) == 0), "R3", "alternate bit", log_q[i], (i % 2) == 0);

        // R10 0.2 FS first-order pattern
        do_reset();
        tag = "R10";
        drive(6554, 1'b0, 40, 0);
        pat = 10'b1010110101;
        for (int i = 0; i < 10; i++)
            check(log_q[i] == pat[9-i], "R10", "pattern bit", log_q[i], pat[9-i]);

        // R9 with R1 R2 R4 streams: DC means in both modes
        foreach (dc[j]) begin
            for (int o = 0; o < 2; o++) begin
                do_reset();
                tag = (o == 1) ? "R4" : "R2";
                drive(dc[j], o[0], 4096, 0);
                mean_chk(dc[j]);
            end
        end

        // R8 idle gaps, then a long hold with changing input
        do_reset();
        tag = "R8";
        drive(9000, 1'b1, 200, 3);
        held = bit_o;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sample_i = 16'(i * 7001 - 20000);
            #1;
            check(bit_o == held, "R8", "bit while idle", bit_o, held);
        end
        drive(-3000, 1'b1, 50, 0);

        // R5 saturation: overdrive then recover, limit observable in stream
        do_reset();
        clamp_lim = 19'd40000;
        tag = "R5";
        drive(32767, 1'b1, 150, 0);
        drive(0, 1'b1, 150, 0);
        drive(-32768, 1'b0, 50, 0);
        drive(5000, 1'b0, 50, 0);
        clamp_lim = '1;

        // R6 run guard active: one 1 then eleven 0s, period 12
        do_reset();
        run_lim = 8'd10;
        tag = "R6";
        drive(-32768, 1'b0, 60, 0);
        check(ones() == 5, "R6", "ones with guard", ones(), 5);

        // R6 guard disabled: single 1 then zeros
        do_reset();
        run_lim = 8'd0;
        drive(-32768, 1'b0, 60, 0);
        check(ones() == 1, "R6", "ones without guard", ones(), 1);

        // R6 second-order overload with guard
        do_reset();
        run_lim = 8'd12;
        drive(30000, 1'b1, 300, 0);
        run_lim = 8'd0;

        check(exp_q.size() == 0, "R1", "queue drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        check(1'b0, "R7", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule